// File: doc/BRIEF.md
# Bit-serial calculator data RAM

This block stands in for the data storage chip beside a bit-serial calculator processor. It keeps sixteen 56-bit data registers. It runs in step with the processor's repeating 56-clock word cycle, in which one word crosses the serial bus one bit per clock, least-significant bit first. A word-sync pulse marks bit 0 of each cycle. A serial instruction line carries a 10-bit instruction in bits 0 to 9 of every cycle. The block decodes the memory operations from it and runs the decoded operation during the following word cycle.

Writes and address loads take the C-register word that the processor drives on the bus during that following cycle. Reads put the chosen register on the bus output and raise a separate output-enable, which tells the processor to release its own C-register drive for that cycle. A word cycle cut short by an early sync pulse abandons the operation running in it.

The state machine has five states:
- `ST_IDLE`: no operation.
- `ST_CLEAR`: zero all registers.
- `ST_LOAD_ADR`: capture the data address.
- `ST_WRITE`: store the bus word.
- `ST_READ`: drive a register onto the bus.

It has three transitions:
- **decode-at-word-end**: on the last bit of a cycle, the state becomes the one picked by that cycle's instruction.
- **abort-on-early-sync**: a sync pulse before bit 55 forces `ST_IDLE`.
- **hold**: the state stays unchanged on every other clock.

Top module: `bit_serial_ram`

## Requirements
- R1: After reset `bus_oe` and `bus_out` are 0, every register holds zero and the data address is 0.
- R2: The instruction {opcode 6'h06, n} (opcode in instruction bits 9..4, n in bits 3..0) reads register n. During the next word cycle `bus_out` carries its bit k at bit time k, and `bus_oe` is high for exactly those 56 clocks, including back-to-back reads.
- R3: `bus_oe` is low and `bus_out` is 0 in every cycle that is not a read cycle.
- R4: Opcode 6'h03 writes the 56-bit bus word of the next cycle into the register at the data address. Opcode 6'h05 does the same into register n. A read issued in the cycle right after a write returns the new value.
- R5: Writing each of the 16 registers through opcode 6'h05 changes only that register.
- R6: Opcode 6'h02 sets the data address to bits 3..0 of the next cycle's bus word. Opcode 6'h04 reads the register at that address.
- R7: Opcode 6'h01 sets all 16 registers to zero and leaves the data address unchanged.
- R8: A sync pulse before bit 55 abandons the running operation. An abandoned write leaves its register unchanged, and an abandoned read drops `bus_oe` from the new cycle onward.
- R9: Every other opcode value (6'h00 and 6'h07 to 6'h3F) changes no register and not the data address, and does not drive the bus.
- R10: Instruction bits are taken at bit times 0 to 9, bit 0 first. The decoded operation runs in the following word cycle, never in the cycle that carried it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one bus bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_sync | input | 1 | High during bit 0 of each word cycle |
| inst_bit | input | 1 | Serial instruction line, bits 0 to 9 of each cycle |
| bus_in | input | 1 | Serial data bus as seen by the RAM (C register when processor drives) |
| bus_out | output | 1 | Serial read data, 0 when not driving |
| bus_oe | output | 1 | High while the RAM owns the data bus |

## Verification
Every register is written through the numbered form with a distinct arithmetic pattern and read back through the numbered form. This separates decode of n from decode of the opcode. Each register is then reached through the address path, where the C word carries noise above bit 3, so a wrong field width or bit order shows up.

A sweep over all 58 unused opcodes, each followed by an all-ones C word, exposes any stray write, address load or bus drive. Back-to-back write/read and read/read pairs, clipped cycles and a clear over filled registers probe the pipeline boundaries, the abort path and the reset-to-zero paths.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    localparam int OP_W = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_LOAD_ADR,
        ST_WRITE,
        ST_READ
    } ram_state_e;

    localparam logic [OP_W-1:0] OP_CLEAR    = 6'h01;
    localparam logic [OP_W-1:0] OP_LOAD_ADR = 6'h02;
    localparam logic [OP_W-1:0] OP_WR_ADR   = 6'h03;
    localparam logic [OP_W-1:0] OP_RD_ADR   = 6'h04;
    localparam logic [OP_W-1:0] OP_WR_N     = 6'h05;
    localparam logic [OP_W-1:0] OP_RD_N     = 6'h06;
endpackage

// File: rtl/bsram_bit_timer.sv
module bsram_bit_timer #(
    parameter int WORD = 56,
    localparam int PW = $clog2(WORD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_sync,
    output logic [PW-1:0] pos,
    output logic          last,
    output logic          abort
);
    logic [PW-1:0] next_q;

    always_comb begin
        pos   = word_sync ? '0 : next_q;
        last  = (pos == PW'(WORD - 1));
        abort = word_sync && (next_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            next_q <= '0;
        else
            next_q <= last ? '0 : pos + 1'b1;
    end

    // R10
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (pos == '0));
endmodule

// File: rtl/bsram_instr_capture.sv
module bsram_instr_capture #(
    parameter int IW   = 10,
    parameter int WORD = 56,
    localparam int PW = $clog2(WORD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inst_bit,
    input  logic [PW-1:0] pos,
    output logic [IW-1:0] instr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr <= '0;
        end else begin
            for (int i = 0; i < IW; i++) begin
                if (pos == PW'(i))
                    instr[i] <= inst_bit;
            end
        end
    end
endmodule

// File: rtl/bsram_store.sv
module bsram_store #(
    parameter int REGS = 16,
    parameter int WORD = 56,
    localparam int AW = $clog2(REGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [WORD-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [WORD-1:0] rdata
);
    logic [WORD-1:0] mem [REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < REGS; g++) mem[g] <= '0;
        end else if (clr) begin
            for (int g = 0; g < REGS; g++) mem[g] <= '0;
        end else if (we) begin
            for (int g = 0; g < REGS; g++)
                if (waddr == AW'(g)) mem[g] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rdata == '0));
    // R7
    clr_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && we));
endmodule

// File: rtl/bit_serial_ram.sv
module bit_serial_ram #(
    parameter int REGS = 16,
    parameter int WORD = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_sync,
    input  logic inst_bit,
    input  logic bus_in,
    output logic bus_out,
    output logic bus_oe
);
    import bsram_pkg::*;

    localparam int AW = $clog2(REGS);
    localparam int IW = OP_W + AW;
    localparam int PW = $clog2(WORD);

    logic [PW-1:0]   pos;
    logic            last;
    logic            abort;
    logic [IW-1:0]   instr;
    logic [OP_W-1:0] opcode;

    ram_state_e state_q, state_d;
    logic [AW-1:0]   n_q, n_d;
    logic            use_n_q, use_n_d;
    logic [AW-1:0]   addr_q;
    logic [WORD-1:0] shift_q;
    logic [WORD-1:0] word_in;
    logic [AW-1:0]   target;
    logic [WORD-1:0] rdata;
    logic            we, clr, ld_adr;

    bsram_bit_timer #(.WORD(WORD)) u_timer (
        .clk(clk), .rst_n(rst_n), .word_sync(word_sync),
        .pos(pos), .last(last), .abort(abort)
    );

    bsram_instr_capture #(.IW(IW), .WORD(WORD)) u_instr (
        .clk(clk), .rst_n(rst_n), .inst_bit(inst_bit),
        .pos(pos), .instr(instr)
    );

    bsram_store #(.REGS(REGS), .WORD(WORD)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .we(we),
        .waddr(target), .wdata(word_in), .raddr(target), .rdata(rdata)
    );

    // Decode of the instruction gathered during the current cycle
    assign opcode = instr[IW-1:AW];

    always_comb begin
        n_d     = instr[AW-1:0];
        use_n_d = 1'b0;
        unique case (opcode)
            OP_CLEAR:    state_d = ST_CLEAR;
            OP_LOAD_ADR: state_d = ST_LOAD_ADR;
            OP_WR_ADR:   state_d = ST_WRITE;
            OP_RD_ADR:   state_d = ST_READ;
            OP_WR_N:   begin state_d = ST_WRITE; use_n_d = 1'b1; end
            OP_RD_N:   begin state_d = ST_READ;  use_n_d = 1'b1; end
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register: decode-at-word-end, abort-on-early-sync, hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            n_q     <= '0;
            use_n_q <= 1'b0;
        end else if (abort) begin
            state_q <= ST_IDLE;
        end else if (last) begin
            state_q <= state_d;
            n_q     <= n_d;
            use_n_q <= use_n_d;
        end
    end

    // Serial intake of the C word, least-significant bit first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shift_q <= '0;
        else if (state_q == ST_WRITE || state_q == ST_LOAD_ADR)
            shift_q <= {bus_in, shift_q[WORD-1:1]};
    end

    assign word_in = {bus_in, shift_q[WORD-1:1]};
    assign target  = use_n_q ? n_q : addr_q;

    // Output process
    always_comb begin
        we      = 1'b0;
        clr     = 1'b0;
        ld_adr  = 1'b0;
        bus_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_CLEAR:    clr    = last && !abort;
            ST_LOAD_ADR: ld_adr = last && !abort;
            ST_WRITE:    we     = last && !abort;
            ST_READ:     bus_oe = !abort;
            default:     ;
        endcase
        bus_out = bus_oe & rdata[pos];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (ld_adr)
            addr_q <= word_in[AW-1:0];
    end

    // R2
    read_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> (pos == '0));
    // R2
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !last) |=> (bus_oe || abort));
    // R3
    read_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> ($past(last) || abort));
    // R8
    abort_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !(we || clr || ld_adr));
    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_q) |-> $past(state_q == ST_LOAD_ADR));
endmodule

// File: tb/test_bit_serial_ram.sv
module test_bit_serial_ram;
    localparam int WORD = 56;
    localparam int REGS = 16;
    localparam logic [5:0] C_CLR = 6'h01, C_LDA = 6'h02, C_WRA = 6'h03,
                           C_RDA = 6'h04, C_WRN = 6'h05, C_RDN = 6'h06;

    logic clk = 1'b0, rst_n = 1'b0, word_sync = 1'b0, inst_bit = 1'b0, bus_in = 1'b0;
    logic bus_out, bus_oe;

    always #5 clk = ~clk;

    bit_serial_ram #(.REGS(REGS), .WORD(WORD)) i_bit_serial_ram (
        .clk(clk), .rst_n(rst_n), .word_sync(word_sync), .inst_bit(inst_bit),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    int n_run = 0, n_fail = 0;
    logic [WORD-1:0] seen;
    int en_cnt, leak;
    logic [WORD-1:0] model [REGS];
    logic [3:0] maddr;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] ins(input logic [5:0] op, input int n);
        return {op, 4'(n)};
    endfunction

    function automatic logic [WORD-1:0] pat(input int r, input int k);
        logic [63:0] x;
        x = 64'h9E37_79B9_7F4A_7C15 * 64'(r * 5 + k * 83 + 1);
        x = x ^ (x >> 29);
        return x[WORD-1:0];
    endfunction

    // One word cycle of nbits bit times; records what the RAM drives
    task automatic cyc(input logic [9:0] i, input logic [WORD-1:0] cw, input int nbits);
        seen = '0; en_cnt = 0; leak = 0;
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            word_sync = (b == 0);
            inst_bit  = (b < 10) ? i[b] : 1'b0;
            bus_in    = cw[b];
            #1;
            if (bus_oe) begin en_cnt++; seen[b] = bus_out; end
            else if (bus_out) leak++;
        end
    endtask

    task automatic rd(input logic [5:0] op, input int r, input logic [WORD-1:0] exp, input string tag);
        cyc(ins(op, r), '0, WORD);
        chk({tag, " R10 no drive in instruction cycle"}, 64'(en_cnt), 0);
        cyc(10'h000, '0, WORD);
        chk({tag, " data"}, 64'(seen), 64'(exp));
        chk({tag, " R2 oe count"}, 64'(en_cnt), 64'(WORD));
    endtask

    task automatic wr(input logic [5:0] op, input int r, input logic [WORD-1:0] v);
        cyc(ins(op, r), '0, WORD);
        cyc(10'h000, v, WORD);
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [WORD-1:0] v;
        int ok;
        for (int r = 0; r < REGS; r++) model[r] = '0;
        maddr = 4'd0;
        repeat (4) @(negedge clk);
        #1;
        chk("R1 oe in reset", 64'(bus_oe), 0);
        chk("R1 out in reset", 64'(bus_out), 0);
        rst_n = 1'b1;

        rd(C_RDN, 0, '0, "R1 reg0 after reset");
        rd(C_RDA, 0, '0, "R1 addressed after reset");

        // R5: numbered writes, then numbered reads
        for (int r = 0; r < REGS; r++) begin
            model[r] = pat(r, 0);
            wr(C_WRN, r, model[r]);
        end
        for (int r = 0; r < REGS; r++) rd(C_RDN, r, model[r], "R5 numbered");

        // R6 / R4: address path with noise above bit 3
        for (int r = 0; r < REGS; r++) begin
            v = (pat(r, 1) << 4) | WORD'(r);
            wr(C_LDA, 0, v);
            maddr = 4'(r);
            model[r] = pat(r, 2);
            wr(C_WRA, 0, model[r]);
            rd(C_RDN, r, model[r], "R4 addressed write");
            rd(C_RDA, 0, model[r], "R6 addressed read");
        end

        // R4: read right after a write to the same register
        v = pat(5, 9);
        cyc(ins(C_WRN, 5), '0, WORD);
        cyc(ins(C_RDN, 5), v, WORD);
        model[5] = v;
        cyc(10'h000, '0, WORD);
        chk("R4 write then read", 64'(seen), 64'(v));
        chk("R2 oe after write", 64'(en_cnt), 64'(WORD));

        // R2: back-to-back reads
        cyc(ins(C_RDN, 3), '0, WORD);
        cyc(ins(C_RDN, 4), '0, WORD);
        chk("R2 first of pair", 64'(seen), 64'(model[3]));
        chk("R2 first oe", 64'(en_cnt), 64'(WORD));
        cyc(10'h000, '0, WORD);
        chk("R2 second of pair", 64'(seen), 64'(model[4]));
        chk("R2 second oe", 64'(en_cnt), 64'(WORD));
        cyc(10'h000, '0, WORD);
        chk("R3 idle after reads", 64'(en_cnt + leak), 0);

        // R9 / R3: every unused opcode followed by an all-ones C word
        ok = 1;
        for (int op = 0; op < 64; op++) begin
            if (op >= 1 && op <= 6) continue;
            cyc(ins(6'(op), op & 15), '1, WORD);
            cyc(10'h000, '1, WORD);
            if (en_cnt != 0 || leak != 0) ok = 0;
        end
        chk("R3 R9 unused opcodes drive nothing", 64'(ok), 1);
        for (int r = 0; r < REGS; r++) rd(C_RDN, r, model[r], "R9 storage kept");
        rd(C_RDA, 0, model[maddr], "R9 address kept");

        // R8: clipped write
        cyc(ins(C_WRN, 7), '0, WORD);
        cyc(10'h000, '1, 30);
        cyc(10'h000, '1, WORD);
        rd(C_RDN, 7, model[7], "R8 aborted write");

        // R8: clipped read
        cyc(ins(C_RDN, 9), '0, WORD);
        cyc(10'h000, '0, 20);
        chk("R8 partial read oe", 64'(en_cnt), 20);
        chk("R8 partial read data", 64'(seen[19:0]), 64'(model[9][19:0]));
        cyc(10'h000, '0, WORD);
        chk("R8 oe dropped after abort", 64'(en_cnt), 0);

        // R7: clear
        cyc(ins(C_CLR, 0), '1, WORD);
        cyc(10'h000, '1, WORD);
        for (int r = 0; r < REGS; r++) model[r] = '0;
        for (int r = 0; r < REGS; r++) rd(C_RDN, r, '0, "R7 cleared");
        v = pat(11, 4);
        wr(C_WRA, 0, v);
        rd(C_RDN, int'(maddr), v, "R7 address survives clear");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule